// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Four-Entry Queue

This block turns an asynchronous, idle-high serial line into bytes. Each character is one low start bit, eight data bits sent least significant first, and one high stop bit. There is no parity. Timing comes from a sample tick at four times the bit rate. The tick is set by a 16-bit divisor: a value of N yields one tick every N+1 clocks. Software therefore programs clock/(4*baud) - 1.

Completed bytes enter a four-entry first-in first-out queue. The oldest byte is always visible at the head output and is removed with a pop strobe. Three level flags report the queue state: empty, full, and exactly one free slot. Two sticky error flags report a missing stop bit and a byte lost to a full queue. Each error flag has its own clear strobe.

Top module: `serial_rx4`

## Requirements
- R1: With divisor N, the sample tick occurs once every N+1 clocks, and one bit period lasts four ticks. Bytes sent at that rate are received correctly for any divisor value.
- R2: A frame is a low start bit, eight data bits with the least significant bit first, and a stop bit. Each data bit is sampled once, in the middle of its bit period.
- R3: A falling edge on the synchronised line starts a frame. The line is checked again two ticks later. If it has gone back high by then, the frame is abandoned and nothing is stored.
- R4: The queue holds up to four bytes in arrival order, and the head output shows the oldest one. A pop strobe removes the head. A pop strobe while the queue is empty has no effect.
- R5: The empty flag is 1 when no bytes are held. The one-slot-left flag is 1 when exactly three bytes are held. The full flag is 1 when four bytes are held.
- R6: When a byte completes while the queue holds four bytes, that byte is discarded and the overrun flag is set. The bytes already held are unchanged.
- R7: When the stop bit is sampled low, the frame-error flag is set. The byte is still stored if there is room.
- R8: Both error flags stay set until their own clear strobe is pulsed. A new error event in the same cycle as a clear takes priority over the clear.
- R9: After synchronous reset, the queue is empty, both error flags are 0, and the one-slot-left and full flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_in | input | 1 | Serial line, idle high, asynchronous |
| divisor | input | 16 | Clocks per sample tick, minus one |
| pop | input | 1 | Remove the head byte |
| clr_frame | input | 1 | Clear the frame-error flag |
| clr_overrun | input | 1 | Clear the overrun flag |
| head_data | output | 8 | Oldest held byte |
| fifo_empty | output | 1 | No byte held |
| fifo_one_left | output | 1 | Exactly three bytes held |
| fifo_full | output | 1 | Four bytes held |
| frame_err | output | 1 | Sticky stop-bit error |
| overrun_err | output | 1 | Sticky lost-byte error |

## Verification
The properties take three things for granted about the inputs:
- the divisor stays constant while a frame is in flight;
- every line level lasts a whole bit period;
- a clear strobe is a single-cycle pulse.

The flag properties otherwise depend only on the frame-complete pulse and the queue level. The bench drives the line through a task that holds every level for exactly four times (divisor+1) clocks. It changes the divisor only while the line is idle. It leaves enough idle time after each stop bit for the byte to reach the queue before it pops or sends again.

// File: rtl/serial_rx4_pkg.sv
package serial_rx4_pkg;
    localparam int OSR      = 4;
    localparam int HALF_OSR = OSR / 2;
    localparam int DATA_W   = 8;
    localparam int PHASE_W  = $clog2(OSR);
    localparam int BIT_W    = $clog2(DATA_W);

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              bad_stop;
    } rx_frame_t;

    function automatic logic [PHASE_W-1:0] phase_last();
        return PHASE_W'(OSR - 1);
    endfunction

    function automatic logic [PHASE_W-1:0] phase_mid();
        return PHASE_W'(HALF_OSR - 1);
    endfunction
endpackage

// File: rtl/serial_rx4_tick.sv
module serial_rx4_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = !restart && (cnt == divisor);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (cnt >= divisor) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/serial_rx4_sync.sv
module serial_rx4_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[g] <= 1'b1;
                    else     pipe[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[g] <= 1'b1;
                    else     pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/serial_rx4_frame.sv
module serial_rx4_frame
    import serial_rx4_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      line,
    input  logic      tick,
    output logic      restart,
    output logic      frame_valid,
    output rx_frame_t frame
);
    rx_state_e           state;
    logic [PHASE_W-1:0]  phase;
    logic [BIT_W-1:0]    bitn;
    logic [DATA_W-1:0]   shreg;
    logic                line_q;
    logic                bad_q;

    assign restart = (state == RX_IDLE) && line_q && !line;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= RX_IDLE;
            phase       <= '0;
            bitn        <= '0;
            shreg       <= '0;
            line_q      <= 1'b1;
            bad_q       <= 1'b0;
            frame_valid <= 1'b0;
        end else begin
            line_q      <= line;
            frame_valid <= 1'b0;
            case (state)
                RX_IDLE: begin
                    phase <= '0;
                    if (restart) state <= RX_START;
                end
                RX_START: if (tick) begin
                    if (phase == phase_mid()) begin
                        phase <= '0;
                        bitn  <= '0;
                        state <= line ? RX_IDLE : RX_DATA;
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                RX_DATA: if (tick) begin
                    if (phase == phase_last()) begin
                        phase <= '0;
                        shreg <= {line, shreg[DATA_W-1:1]};
                        if (bitn == BIT_W'(DATA_W - 1)) state <= RX_STOP;
                        else                            bitn  <= bitn + 1'b1;
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                RX_STOP: if (tick) begin
                    if (phase == phase_last()) begin
                        phase       <= '0;
                        bad_q       <= !line;
                        frame_valid <= 1'b1;
                        state       <= RX_IDLE;
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign frame.data     = shreg;
    assign frame.bad_stop = bad_q;
endmodule

// File: rtl/serial_rx4_fifo.sv
module serial_rx4_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop  && (count != '0);
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/serial_rx4.sv
module serial_rx4
    import serial_rx4_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int DEPTH      = 4,
    parameter int SYNC_DEPTH = 2,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd_in,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              pop,
    input  logic              clr_frame,
    input  logic              clr_overrun,
    output logic [DATA_W-1:0] head_data,
    output logic              fifo_empty,
    output logic              fifo_one_left,
    output logic              fifo_full,
    output logic              frame_err,
    output logic              overrun_err
);
    logic      line_s;
    logic      restart;
    logic      tick;
    logic      frm_valid;
    logic      frm_bad;
    rx_frame_t frm;
    logic [CW-1:0] level;

    serial_rx4_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .din(rxd_in), .dout(line_s)
    );

    serial_rx4_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .restart(restart), .divisor(divisor), .tick(tick)
    );

    serial_rx4_frame u_frame (
        .clk(clk), .rst(rst), .line(line_s), .tick(tick),
        .restart(restart), .frame_valid(frm_valid), .frame(frm)
    );

    assign frm_bad = frm.bad_stop;

    serial_rx4_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(frm_valid), .push_data(frm.data),
        .pop(pop), .head(head_data), .count(level)
    );

    assign fifo_empty    = (level == '0);
    assign fifo_full     = (level == CW'(DEPTH));
    assign fifo_one_left = (level == CW'(DEPTH - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_err   <= 1'b0;
            overrun_err <= 1'b0;
        end else begin
            if (frm_valid && frm_bad) frame_err <= 1'b1;
            else if (clr_frame)       frame_err <= 1'b0;
            if (frm_valid && fifo_full) overrun_err <= 1'b1;
            else if (clr_overrun)       overrun_err <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_rx4_chk.sv
module serial_rx4_chk (
    input logic clk,
    input logic rst,
    input logic pop,
    input logic clr_frame,
    input logic clr_overrun,
    input logic fifo_empty,
    input logic fifo_one_left,
    input logic fifo_full,
    input logic frame_err,
    input logic overrun_err,
    input logic frame_valid,
    input logic frame_bad
);
    AST_LEVEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> (!fifo_empty && !fifo_one_left)); // R5

    AST_EMPTY_STEP: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |=> (!fifo_full && !fifo_one_left)); // R5

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && !pop) |=> fifo_full); // R4

    AST_OVERRUN_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && fifo_full) |=> overrun_err); // R6

    AST_FRAME_FLAG: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && frame_bad) |=> frame_err); // R7

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overrun_err && !clr_overrun) |=> overrun_err); // R8

    AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (rst)
        (frame_err && !clr_frame) |=> frame_err); // R8

    AST_OVERRUN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_overrun && !(frame_valid && fifo_full)) |=> !overrun_err); // R8
endmodule

bind serial_rx4 serial_rx4_chk u_chk (
    .clk(clk), .rst(rst), .pop(pop), .clr_frame(clr_frame),
    .clr_overrun(clr_overrun), .fifo_empty(fifo_empty),
    .fifo_one_left(fifo_one_left), .fifo_full(fifo_full),
    .frame_err(frame_err), .overrun_err(overrun_err),
    .frame_valid(frm_valid), .frame_bad(frm_bad)
);

// File: tb/serial_rx4_bench.sv
module serial_rx4_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rxd_in = 1'b1;
    logic [15:0] divisor = 16'd1;
    logic        pop = 1'b0;
    logic        clr_frame = 1'b0;
    logic        clr_overrun = 1'b0;
    logic [7:0]  head_data;
    logic        fifo_empty, fifo_one_left, fifo_full, frame_err, overrun_err;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    serial_rx4 u_serial_rx4 (
        .clk(clk), .rst(rst), .rxd_in(rxd_in), .divisor(divisor), .pop(pop),
        .clr_frame(clr_frame), .clr_overrun(clr_overrun), .head_data(head_data),
        .fifo_empty(fifo_empty), .fifo_one_left(fifo_one_left),
        .fifo_full(fifo_full), .frame_err(frame_err), .overrun_err(overrun_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int ticks);
        rxd_in = v;
        repeat (ticks * (int'(divisor) + 1)) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic stop_v);
        hold(1'b0, 4);
        for (int i = 0; i < 8; i++) hold(d[i], 4);
        hold(stop_v, 4);
        rxd_in = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic pulse_pop();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_levels(input string req, input int n);
        chk(req, "empty",    16'(fifo_empty),    16'(n == 0));
        chk(req, "one_left", 16'(fifo_one_left), 16'(n == 3));
        chk(req, "full",     16'(fifo_full),     16'(n == 4));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check_levels("R9", 0);
        chk("R9", "frame_err",   16'(frame_err),   16'h0);
        chk("R9", "overrun_err", 16'(overrun_err), 16'h0);

        // R2: every byte value, LSB first, at divisor 1
        divisor = 16'd1;
        for (int v = 0; v < 256; v++) begin
            send(8'(v), 1'b1);
            chk("R2", "head", 16'(head_data), 16'(v));
            chk("R2", "nonempty", 16'(fifo_empty), 16'h0);
            pulse_pop();
        end

        // R1: several divisors, a few patterns each
        for (int k = 0; k < 4; k++) begin
            logic [15:0] dv;
            dv = (k == 0) ? 16'd0 : (k == 1) ? 16'd2 : (k == 2) ? 16'd5 : 16'd12;
            divisor = dv;
            repeat (4) @(negedge clk);
            for (int j = 0; j < 3; j++) begin
                logic [7:0] b;
                b = 8'((k * 37 + j * 91 + 5) ^ 8'h5A);
                send(b, 1'b1);
                chk("R1", "head", 16'(head_data), 16'(b));
                pulse_pop();
                check_levels("R1", 0);
            end
        end

        // R3: short low glitch abandoned
        divisor = 16'd3;
        repeat (4) @(negedge clk);
        hold(1'b0, 1);
        rxd_in = 1'b1;
        repeat (60) @(negedge clk);
        check_levels("R3", 0);
        chk("R3", "frame_err", 16'(frame_err), 16'h0);
        send(8'h3C, 1'b1);
        chk("R3", "head after glitch", 16'(head_data), 16'h3C);
        pulse_pop();

        // R4: pop on empty ignored, then level ladder
        pulse_pop();
        check_levels("R4", 0);
        for (int i = 0; i < 4; i++) begin
            send(8'hA0 + 8'(i), 1'b1);
            check_levels("R5", i + 1);
        end
        // R6: fifth byte dropped, overrun set
        send(8'hEE, 1'b1);
        chk("R6", "overrun_err", 16'(overrun_err), 16'h1);
        check_levels("R6", 4);
        for (int i = 0; i < 4; i++) begin
            chk("R4", "order", 16'(head_data), 16'(8'hA0 + 8'(i)));
            pulse_pop();
            check_levels("R4", 3 - i);
        end
        // R8: overrun sticky until cleared
        chk("R8", "overrun held", 16'(overrun_err), 16'h1);
        clr_overrun = 1'b1;
        @(negedge clk);
        clr_overrun = 1'b0;
        @(negedge clk);
        chk("R8", "overrun cleared", 16'(overrun_err), 16'h0);

        // R7: bad stop sets flag, byte still stored
        send(8'h96, 1'b0);
        chk("R7", "frame_err", 16'(frame_err), 16'h1);
        chk("R7", "stored", 16'(head_data), 16'h96);
        check_levels("R7", 1);
        pulse_pop();
        send(8'h11, 1'b1);
        chk("R8", "frame sticky", 16'(frame_err), 16'h1);
        chk("R7", "good after bad", 16'(head_data), 16'h11);
        pulse_pop();
        clr_frame = 1'b1;
        @(negedge clk);
        clr_frame = 1'b0;
        @(negedge clk);
        chk("R8", "frame cleared", 16'(frame_err), 16'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule